// File: doc/BRIEF.md
# Successive-Approximation Converter Digital Interface Emulator

This block stands in for the digital side of a 12-bit successive-approximation converter, so that a host controller can be verified against a cycle-accurate model of the converter's control and read-back behaviour. The host drives an active-low chip select and a read/convert strobe. A strobe level of low means convert and high means read. The block combines the two inputs to find conversion-start events and the read window. While a conversion runs it holds `busy` low for a configurable number of clock cycles. At the start edge it captures a 12-bit stimulus value, and at the end of the conversion it moves that value into the output register.

The result comes out on a 16-bit bus with an enable, which models the tri-state lines. A byte-order input picks between two layouts. In the straight layout the result sits in the top twelve lines with zero padding below. In the swapped layout the low four result bits sit in the top nibble, four zero lines follow, and the upper eight result bits occupy the low byte. The block also reports three kinds of host misuse. First, a start request that arrives during a conversion is dropped and counted. Second, a conversion that starts again on its own because both inputs were low when `busy` rose is flagged. Third, a start that comes too soon after the previous completion is flagged as an acquisition violation.

The control core is a three-state machine. In IDLE, `busy` is high. In CONVERT, the counter runs and `busy` is low. In LATCH, `busy` is still low and the result register loads. The transitions are as follows. IDLE goes to CONVERT on an accepted start, which is either a start edge or a restart at the completion point. CONVERT goes to LATCH when the cycle counter reaches zero. LATCH always returns to IDLE.

Top module: `sar_adc_if_emu`

## Requirements
- R1: After reset `busy` is 1, `acq_viol` is 0, `ign_cnt` is 0, and the output register holds zero.
- R2: A falling edge of `rd_conv` while `cs_n` is low starts a conversion; `busy` is low in the cycle after the edge is sampled.
- R3: A falling edge of `cs_n` while `rd_conv` is low starts a conversion in the same way.
- R4: `busy` stays low for exactly CONV_CYCLES+1 clock cycles. When it rises, the output register holds the `sample_in` value that was captured at the start edge.
- R5: `bus_en` is 1 exactly when `cs_n` is 0 and `rd_conv` is 1. Whenever `bus_en` is 0, `bus_d` is all zeros.
- R6: With `byte_sel` = 0, `bus_d` = {result[11:0], 4'b0}. With `byte_sel` = 1, `bus_d` = {result[3:0], 4'b0, result[11:4]}.
- R7: A start edge that arrives while `busy` is low starts nothing and raises `ign_cnt` by one, saturating at all ones.
- R8: If `cs_n` and `rd_conv` are both low in the first cycle after `busy` rises, `auto_restart` is 1 in that cycle and a new conversion begins, so `busy` is low in the next cycle.
- R9: `acq_viol` becomes 1 when a conversion starts fewer than ACQ_MIN cycles after the last rise of `busy`. It stays 1 until reset.
- R10: The output register keeps the previous result throughout a conversion and changes only at completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select |
| rd_conv | input | 1 | Strobe: low = convert, high = read |
| byte_sel | input | 1 | Output byte order: 0 straight, 1 swapped |
| sample_in | input | RES_W | Stimulus value captured at conversion start |
| busy | output | 1 | Low while a conversion is in progress |
| bus_en | output | 1 | Output lines driven (1) or high impedance (0) |
| bus_d | output | BUS_W | Formatted output data, zero when not driven |
| auto_restart | output | 1 | A conversion restarts as busy rises |
| acq_viol | output | 1 | Sticky acquisition-time violation |
| ign_cnt | output | CNT_W | Count of start requests dropped while busy |

## Verification
The bench targets both start paths: a strobe fall under a low chip select, and a chip-select fall under a low strobe. A decoder that knows only one of them leaves `busy` high on the other. It issues start edges in the middle of a conversion. A design that honours them restarts the counter, which makes the low period too long, and leaves `ign_cnt` unchanged. It reads the bus during a conversion and again in both byte orders. This exposes a result register that updates at the start edge and a swap that misplaces the zero nibble. Finally it holds both inputs low through completion. This confirms that `busy` rises for exactly one cycle before the conversion restarts, and that the acquisition flag catches the restart while normal spacing leaves it clear.

// File: rtl/sar_emu_pkg.sv
package sar_emu_pkg;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_CONV  = 2'd1,
        S_LATCH = 2'd2
    } conv_state_e;

endpackage

// File: rtl/sar_evt_decode.sv
// Turns the chip-select and strobe pins into a start pulse, a low-level flag and a read window.
module sar_evt_decode (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic rd_conv,
    output logic start_evt,
    output logic both_low,
    output logic rd_win
);
    logic gate_now;
    logic gate_q;

    // Chip select and strobe combine as an OR; a fall of the combined level starts a conversion.
    assign gate_now = cs_n | rd_conv;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gate_q <= 1'b1;
        else        gate_q <= gate_now;
    end

    assign start_evt = gate_q & ~gate_now;
    assign both_low  = ~gate_now;
    assign rd_win    = ~cs_n & rd_conv;

endmodule

// File: rtl/sar_conv_fsm.sv
module sar_conv_fsm
    import sar_emu_pkg::*;
#(
    parameter int RES_W       = 12,
    parameter int CONV_CYCLES = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_evt,
    input  logic             both_low,
    input  logic [RES_W-1:0] sample_in,
    output logic             busy,
    output logic             auto_restart,
    output logic             start_ok,
    output logic             start_drop,
    output logic             latch_pulse,
    output logic [RES_W-1:0] res_q
);
    localparam int CW = $clog2(CONV_CYCLES + 1);

    conv_state_e      state_q, state_d;
    logic [CW-1:0]    cnt_q;
    logic [RES_W-1:0] hold_q;
    logic             fresh_q;
    logic             in_idle;
    logic             go;

    assign in_idle = (state_q == S_IDLE);
    assign go      = in_idle & (start_evt | (fresh_q & both_low));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (go) state_d = S_CONV;
            S_CONV:  if (cnt_q == '0) state_d = S_LATCH;
            S_LATCH: state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            cnt_q   <= '0;
            hold_q  <= '0;
            res_q   <= '0;
            fresh_q <= 1'b0;
        end else begin
            state_q <= state_d;
            fresh_q <= (state_q == S_LATCH);
            if (go) begin
                cnt_q  <= CW'(CONV_CYCLES - 1);
                hold_q <= sample_in;
            end else if (state_q == S_CONV && cnt_q != '0) begin
                cnt_q <= cnt_q - 1'b1;
            end
            if (state_q == S_LATCH) res_q <= hold_q;
        end
    end

    always_comb begin
        busy         = in_idle;
        auto_restart = in_idle & fresh_q & both_low;
        start_ok     = go;
        start_drop   = start_evt & ~in_idle;
        latch_pulse  = (state_q == S_LATCH);
    end

endmodule

// File: rtl/sar_err_track.sv
// Counts dropped starts and flags starts that come before the acquisition window has passed.
module sar_err_track #(
    parameter int ACQ_MIN = 4,
    parameter int CNT_W   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             latch_pulse,
    input  logic             in_idle,
    input  logic             start_ok,
    input  logic             start_drop,
    output logic             acq_viol,
    output logic [CNT_W-1:0] ign_cnt
);
    localparam int AW = $clog2(ACQ_MIN + 1);

    logic [AW-1:0] acq_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acq_q    <= AW'(ACQ_MIN);
            acq_viol <= 1'b0;
            ign_cnt  <= '0;
        end else begin
            if (latch_pulse)
                acq_q <= '0;
            else if (in_idle && acq_q < AW'(ACQ_MIN))
                acq_q <= acq_q + 1'b1;
            if (start_ok && acq_q < AW'(ACQ_MIN))
                acq_viol <= 1'b1;
            if (start_drop && ign_cnt != '1)
                ign_cnt <= ign_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/sar_bus_fmt.sv
module sar_bus_fmt #(
    parameter int RES_W = 12,
    parameter int BUS_W = 16
) (
    input  logic             rd_win,
    input  logic             byte_sel,
    input  logic [RES_W-1:0] res_q,
    output logic             bus_en,
    output logic [BUS_W-1:0] bus_d
);
    localparam int PAD_W = BUS_W - RES_W;
    localparam int HI_W  = 8;
    localparam int LO_W  = RES_W - HI_W;

    logic [BUS_W-1:0] straight;
    logic [BUS_W-1:0] swapped;

    assign straight = {res_q, {PAD_W{1'b0}}};
    assign swapped  = {res_q[LO_W-1:0], {PAD_W{1'b0}}, res_q[RES_W-1:LO_W]};

    always_comb begin
        bus_en = rd_win;
        if (!rd_win)       bus_d = '0;
        else if (byte_sel) bus_d = swapped;
        else               bus_d = straight;
    end

endmodule

// File: rtl/sar_adc_if_emu.sv
module sar_adc_if_emu #(
    parameter int RES_W       = 12,
    parameter int BUS_W       = 16,
    parameter int CONV_CYCLES = 12,
    parameter int ACQ_MIN     = 4,
    parameter int CNT_W       = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             rd_conv,
    input  logic             byte_sel,
    input  logic [RES_W-1:0] sample_in,
    output logic             busy,
    output logic             bus_en,
    output logic [BUS_W-1:0] bus_d,
    output logic             auto_restart,
    output logic             acq_viol,
    output logic [CNT_W-1:0] ign_cnt
);
    logic             start_evt;
    logic             both_low;
    logic             rd_win;
    logic             start_ok;
    logic             start_drop;
    logic             latch_pulse;
    logic [RES_W-1:0] res_q;

    sar_evt_decode u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .rd_conv   (rd_conv),
        .start_evt (start_evt),
        .both_low  (both_low),
        .rd_win    (rd_win)
    );

    sar_conv_fsm #(.RES_W(RES_W), .CONV_CYCLES(CONV_CYCLES)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_evt    (start_evt),
        .both_low     (both_low),
        .sample_in    (sample_in),
        .busy         (busy),
        .auto_restart (auto_restart),
        .start_ok     (start_ok),
        .start_drop   (start_drop),
        .latch_pulse  (latch_pulse),
        .res_q        (res_q)
    );

    sar_err_track #(.ACQ_MIN(ACQ_MIN), .CNT_W(CNT_W)) u_err (
        .clk         (clk),
        .rst_n       (rst_n),
        .latch_pulse (latch_pulse),
        .in_idle     (busy),
        .start_ok    (start_ok),
        .start_drop  (start_drop),
        .acq_viol    (acq_viol),
        .ign_cnt     (ign_cnt)
    );

    sar_bus_fmt #(.RES_W(RES_W), .BUS_W(BUS_W)) u_fmt (
        .rd_win   (rd_win),
        .byte_sel (byte_sel),
        .res_q    (res_q),
        .bus_en   (bus_en),
        .bus_d    (bus_d)
    );

endmodule

// File: rtl/sar_adc_if_chk.sv
module sar_adc_if_chk #(
    parameter int RES_W       = 12,
    parameter int BUS_W       = 16,
    parameter int CONV_CYCLES = 12,
    parameter int CNT_W       = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cs_n,
    input logic             busy,
    input logic             bus_en,
    input logic [BUS_W-1:0] bus_d,
    input logic             auto_restart,
    input logic             acq_viol,
    input logic [CNT_W-1:0] ign_cnt,
    input logic             start_evt,
    input logic [RES_W-1:0] res_q
);
    logic [15:0] low_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    low_run <= '0;
        else if (busy) low_run <= '0;
        else           low_run <= low_run + 1'b1;
    end

    p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start_evt) |=> !busy);

    p_low_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (low_run == 16'(CONV_CYCLES + 1)));

    p_idle_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_en |-> (bus_d == '0));

    p_cs_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !bus_en);

    p_drop_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (start_evt && !busy && ign_cnt != '1) |=> (ign_cnt == $past(ign_cnt) + 1'b1));

    p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        auto_restart |-> busy);

    p_restart_next_r8: assert property (@(posedge clk) disable iff (!rst_n)
        auto_restart |=> !busy);

    p_viol_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        acq_viol |=> acq_viol);

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> (busy || $stable(res_q)));

endmodule

bind sar_adc_if_emu sar_adc_if_chk #(
    .RES_W(RES_W), .BUS_W(BUS_W), .CONV_CYCLES(CONV_CYCLES), .CNT_W(CNT_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cs_n         (cs_n),
    .busy         (busy),
    .bus_en       (bus_en),
    .bus_d        (bus_d),
    .auto_restart (auto_restart),
    .acq_viol     (acq_viol),
    .ign_cnt      (ign_cnt),
    .start_evt    (start_evt),
    .res_q        (res_q)
);

// File: tb/tb_sar_adc_if_emu.sv
`timescale 1ns/1ps
module tb_sar_adc_if_emu;
    localparam int TB_CONV = 12;
    localparam int TB_ACQ  = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, rd_conv = 1'b1, byte_sel = 1'b0;
    logic [11:0] sample_in = '0;
    logic        busy, bus_en, auto_restart, acq_viol;
    logic [15:0] bus_d;
    logic [3:0]  ign_cnt;

    int checks = 0, errors = 0;
    bit done = 0, mon_on = 0;
    logic [11:0] exp_q[$];
    logic [11:0] prev_res = '0;

    always #2 clk = ~clk;

    sar_adc_if_emu #(.CONV_CYCLES(TB_CONV), .ACQ_MIN(TB_ACQ)) dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_conv(rd_conv), .byte_sel(byte_sel),
        .sample_in(sample_in), .busy(busy), .bus_en(bus_en), .bus_d(bus_d),
        .auto_restart(auto_restart), .acq_viol(acq_viol), .ign_cnt(ign_cnt)
    );

    function automatic logic [15:0] fmt(input logic [11:0] v, input logic bs);
        return bs ? {v[3:0], 4'h0, v[11:4]} : {v, 4'h0};
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Monitor: on each rise of busy, check the low period and compare the bus with the queued value.
    int  low_run = 0;
    logic prev_busy = 1'b1;
    always @(negedge clk) begin
        if (mon_on) begin
            if (!busy) low_run++;
            else if (!prev_busy) begin
                check(low_run == TB_CONV + 1, "R4 busy low length", low_run, TB_CONV + 1);
                low_run = 0;
                if (exp_q.size() == 0) check(0, "R4 unexpected completion", 0, 1);
                else begin
                    prev_res = exp_q.pop_front();
                    if (bus_en)
                        check(bus_d == fmt(prev_res, byte_sel), byte_sel ? "R6 swapped result" : "R4 result",
                              bus_d, fmt(prev_res, byte_sel));
                end
            end
            prev_busy = busy;
        end
    end

    task automatic wait_done();
        while (!busy) @(negedge clk);
        repeat (TB_ACQ + 4) @(negedge clk);
    endtask

    task automatic conv_strobe(input logic [11:0] v);
        logic [11:0] old;
        old = prev_res;
        cs_n = 1'b0; rd_conv = 1'b1; sample_in = v;
        @(negedge clk) rd_conv = 1'b0; exp_q.push_back(v);
        @(negedge clk);
        check(busy == 1'b0, "R2 strobe start", busy, 0);
        sample_in = ~v;
        rd_conv = 1'b1;
        @(negedge clk); #0.5;
        check(bus_d == fmt(old, byte_sel), "R10 previous result held", bus_d, fmt(old, byte_sel));
        @(negedge clk);
        wait_done();
    endtask

    task automatic conv_cs(input logic [11:0] v);
        cs_n = 1'b1; rd_conv = 1'b0; sample_in = v;
        @(negedge clk) cs_n = 1'b0; exp_q.push_back(v);
        @(negedge clk);
        check(busy == 1'b0, "R3 chip-select start", busy, 0);
        check(bus_en == 1'b0, "R5 no drive with strobe low", bus_en, 0);
        rd_conv = 1'b1;
        @(negedge clk);
        wait_done();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1; mon_on = 1;
        @(negedge clk);
        check(busy == 1'b1, "R1 busy after reset", busy, 1);
        check(acq_viol == 1'b0, "R1 flag after reset", acq_viol, 0);
        check(ign_cnt == 4'd0, "R1 counter after reset", ign_cnt, 0);
        check(bus_en == 1'b0 && bus_d == 16'h0, "R5 idle bus off", bus_d, 0);
        cs_n = 1'b0; #0.5;
        check(bus_en == 1'b1 && bus_d == 16'h0, "R1 zero result read", bus_d, 0);
        @(negedge clk);

        conv_strobe(12'hA5C);
        conv_cs(12'h3E7);
        byte_sel = 1'b1;
        conv_strobe(12'h9B1);
        cs_n = 1'b0; rd_conv = 1'b1; #0.5;
        check(bus_d == 16'h109B, "R6 swapped layout", bus_d, 16'h109B);
        byte_sel = 1'b0; #0.5;
        check(bus_d == 16'h9B10, "R6 straight layout", bus_d, 16'h9B10);
        @(negedge clk);

        // R7: two start edges during a conversion are dropped and counted
        sample_in = 12'h456;
        @(negedge clk) rd_conv = 1'b0; exp_q.push_back(12'h456);
        @(negedge clk) rd_conv = 1'b1;
        @(negedge clk) rd_conv = 1'b0;
        @(negedge clk) rd_conv = 1'b1;
        @(negedge clk) cs_n = 1'b1;
        @(negedge clk) rd_conv = 1'b0;
        @(negedge clk) cs_n = 1'b0;
        @(negedge clk) rd_conv = 1'b1;
        check(busy == 1'b0, "R7 still converting", busy, 0);
        wait_done();
        check(ign_cnt == 4'd2, "R7 dropped starts counted", ign_cnt, 2);
        check(acq_viol == 1'b0, "R9 no violation with spacing", acq_viol, 0);

        // R8/R9: both inputs held low through completion
        cs_n = 1'b0; rd_conv = 1'b1; sample_in = 12'h111;
        @(negedge clk) rd_conv = 1'b0; exp_q.push_back(12'h111);
        @(negedge clk);
        while (!busy) @(negedge clk);
        check(auto_restart == 1'b1, "R8 restart flagged", auto_restart, 1);
        sample_in = 12'h7C2; exp_q.push_back(12'h7C2);
        @(negedge clk);
        check(busy == 1'b0, "R8 restart converts", busy, 0);
        check(acq_viol == 1'b1, "R9 violation set", acq_viol, 1);
        rd_conv = 1'b1;
        @(negedge clk);
        wait_done();
        check(acq_viol == 1'b1, "R9 violation sticky", acq_viol, 1);
        check(prev_res == 12'h7C2 && exp_q.size() == 0, "R8 second result", prev_res, 12'h7C2);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule